// File: doc/BRIEF.md
# Successive-Approximation Controller with Mid-Level Capacitor Switching

This block is the digital sequencer of a 12-bit charge-redistribution converter whose input is sampled on the top plates of the capacitor array. A start request opens a sample window. The capacitor bottom plates rest at the common-mode level throughout that window. The controller then strobes the comparator once per clock, most significant bit first. The first decision needs no switching, because the sampled top plate is compared directly against the common-mode level.

Each later decision moves one capacitor away from the common-mode level, toward the low or the high reference. Eleven three-level drivers therefore resolve twelve bits. They are split into an upper segment of six capacitors and a lower segment of five. When the last bit is stored, the controller returns every driver to the common-mode level and pulses `done_o`. The result then stays on `result_o` until the next conversion starts. The comparator, the capacitor array, the switches and the references are analog circuits outside this block.

Top module: `sar_vcm_ctrl`

## Requirements
- R1: A start request in idle makes `sample_o` high for exactly SAMPLE_CYC (default 2) cycles, starting in the cycle after the request. All drivers read 00 (common mode) throughout the window.
- R2: After the sample window, `cmp_strobe_o` is high for exactly 12 consecutive cycles, one per bit, from bit 11 down to bit 0. It is never high together with `sample_o`. In the first strobe cycle all drivers are still at common mode.
- R3: The decision in the strobe cycle of bit k (k from 11 down to 1) sets capacitor k-1 from the next cycle on. Decision 1 gives positive code 01 (low reference) and negative code 10. Decision 0 gives positive code 10 (high reference) and negative code 01. The code 11 never appears, and no other capacitor changes.
- R4: The decision for bit 0 changes no driver.
- R5: Result bit k equals the comparator decision in the strobe cycle of bit k. With an ideal comparator, the result equals the input code for all 4096 codes.
- R6: `done_o` is high for exactly one cycle, the cycle after the last strobe. In that same cycle all drivers are back at 00 and `result_o` holds the full result.
- R7: `result_o` reads 0 in the first sample cycle. It is stable in every idle cycle until the next start is accepted.
- R8: A start request during sampling or conversion is ignored. It neither lengthens nor restarts the current operation.
- R9: While `rst_ni` is low, the block is idle: all outputs are 0 and every driver is at common mode.
- R10: Capacitors 10 to 5 appear on the upper-segment ports, with capacitor 5 at bits 1:0. Capacitors 4 to 0 appear on the lower-segment ports, with capacitor 0 at bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one bit per rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request, taken only in idle |
| cmp_i | input | 1 | Comparator decision, 1 = sampled input above trial level |
| sample_o | output | 1 | Top-plate sample switch enable |
| cmp_strobe_o | output | 1 | Comparator strobe, one per bit |
| cap_hi_p_o | output | 12 | Positive-side codes, upper segment (capacitors 10..5) |
| cap_hi_n_o | output | 12 | Negative-side codes, upper segment |
| cap_lo_p_o | output | 10 | Positive-side codes, lower segment (capacitors 4..0) |
| cap_lo_n_o | output | 10 | Negative-side codes, lower segment |
| result_o | output | 12 | Conversion result |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps all 4096 codes with an ideal charge-balance comparator and checks the driver pattern in every strobe cycle. An off-by-one between bit index and capacitor index would then show up as a wrong capacitor moving, or as a skewed result near the segment boundary between capacitors 5 and 4. An inverted driver polarity would make the search diverge, which shows up as results pinned near 0 or 4095. Start pulses are sprinkled through the sample and conversion phases, so a design that re-arms on them would stretch `sample_o` or cut the strobe train short. Idle gaps of varying length between conversions catch a result that is not held, a `done_o` longer than one cycle, and drivers left off the common-mode level.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    LVL_VCM = 2'b00,
    LVL_LO  = 2'b01,
    LVL_HI  = 2'b10
  } lvl_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_CONV
  } st_e;

  function automatic lvl_e lvl_mirror(lvl_e l);
    case (l)
      LVL_LO:  return LVL_HI;
      LVL_HI:  return LVL_LO;
      default: return LVL_VCM;
    endcase
  endfunction
endpackage

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int NBITS      = 12,
  parameter int SAMPLE_CYC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             accept_o,
  output logic             sample_o,
  output logic             conv_o,
  output logic             last_o,
  output logic             done_o,
  output logic [NBITS-1:0] bit_en_o
);
  import sar_pkg::*;

  localparam int PW = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam int CW = (SAMPLE_CYC > 1) ? $clog2(SAMPLE_CYC) : 1;
  localparam logic [PW-1:0] PTR_TOP  = PW'(NBITS - 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(SAMPLE_CYC - 1);

  st_e           state_q;
  logic [PW-1:0] ptr_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign accept_o = (state_q == ST_IDLE) && start_i;
  assign sample_o = (state_q == ST_SAMPLE);
  assign conv_o   = (state_q == ST_CONV);
  assign last_o   = conv_o && (ptr_q == '0);
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last_o;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_SAMPLE;
            cnt_q   <= '0;
          end
        end
        ST_SAMPLE: begin
          if (cnt_q == CNT_LAST) begin
            state_q <= ST_CONV;
            ptr_q   <= PTR_TOP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_CONV: begin
          if (ptr_q == '0) state_q <= ST_IDLE;
          else             ptr_q   <= ptr_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < NBITS; i++) begin : g_en
    assign bit_en_o[i] = conv_o && (ptr_q == PW'(i));
  end
endmodule

// File: rtl/sar_cap_drv.sv
module sar_cap_drv (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic          dec_i,
  output sar_pkg::lvl_e lvl_p_o,
  output sar_pkg::lvl_e lvl_n_o
);
  import sar_pkg::*;

  lvl_e lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lvl_q <= LVL_VCM;
    else if (clr_i)   lvl_q <= LVL_VCM;
    else if (en_i)    lvl_q <= dec_i ? LVL_LO : LVL_HI; // pull residue back toward mid
  end

  assign lvl_p_o = lvl_q;
  assign lvl_n_o = lvl_mirror(lvl_q);
endmodule

// File: rtl/sar_result.sv
module sar_result #(
  parameter int NBITS = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [NBITS-1:0] bit_en_i,
  input  logic             dec_i,
  output logic [NBITS-1:0] res_o
);
  for (genvar k = 0; k < NBITS; k++) begin : g_bit
    logic b_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          b_q <= 1'b0;
      else if (clr_i)       b_q <= 1'b0;
      else if (bit_en_i[k]) b_q <= dec_i;
    end
    assign res_o[k] = b_q;
  end
endmodule

// File: rtl/sar_vcm_ctrl.sv
module sar_vcm_ctrl #(
  parameter int NBITS      = 12,
  parameter int NHI        = 6,
  parameter int SAMPLE_CYC = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic                          cmp_i,
  output logic                          sample_o,
  output logic                          cmp_strobe_o,
  output logic [2*NHI-1:0]              cap_hi_p_o,
  output logic [2*NHI-1:0]              cap_hi_n_o,
  output logic [2*(NBITS-1-NHI)-1:0]    cap_lo_p_o,
  output logic [2*(NBITS-1-NHI)-1:0]    cap_lo_n_o,
  output logic [NBITS-1:0]              result_o,
  output logic                          done_o
);
  import sar_pkg::*;

  localparam int NCAP = NBITS - 1;
  localparam int NLO  = NCAP - NHI;

  logic             accept, conv, last;
  logic [NBITS-1:0] bit_en;
  logic             drv_clr;

  sar_seq #(.NBITS(NBITS), .SAMPLE_CYC(SAMPLE_CYC)) i_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .accept_o (accept),
    .sample_o (sample_o),
    .conv_o   (conv),
    .last_o   (last),
    .done_o   (done_o),
    .bit_en_o (bit_en)
  );

  assign cmp_strobe_o = conv;
  assign drv_clr      = accept | last;

  sar_result #(.NBITS(NBITS)) i_res (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (accept),
    .bit_en_i (bit_en),
    .dec_i    (cmp_i),
    .res_o    (result_o)
  );

  for (genvar j = 0; j < NCAP; j++) begin : g_cap
    lvl_e lp, ln;
    sar_cap_drv i_drv (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (drv_clr),
      .en_i    (bit_en[j+1]),
      .dec_i   (cmp_i),
      .lvl_p_o (lp),
      .lvl_n_o (ln)
    );
    if (j >= NLO) begin : g_hi
      assign cap_hi_p_o[2*(j-NLO) +: 2] = lp;
      assign cap_hi_n_o[2*(j-NLO) +: 2] = ln;
    end else begin : g_lo
      assign cap_lo_p_o[2*j +: 2] = lp;
      assign cap_lo_n_o[2*j +: 2] = ln;
    end
  end
endmodule

// File: rtl/sar_vcm_ctrl_chk.sv
module sar_vcm_ctrl_chk #(
  parameter int NBITS      = 12,
  parameter int NHI        = 6,
  parameter int SAMPLE_CYC = 2
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       start_i,
  input logic                       cmp_i,
  input logic                       sample_o,
  input logic                       cmp_strobe_o,
  input logic [2*NHI-1:0]           cap_hi_p_o,
  input logic [2*NHI-1:0]           cap_hi_n_o,
  input logic [2*(NBITS-1-NHI)-1:0] cap_lo_p_o,
  input logic [2*(NBITS-1-NHI)-1:0] cap_lo_n_o,
  input logic [NBITS-1:0]           result_o,
  input logic                       done_o
);
  localparam int NCAP = NBITS - 1;

  logic [2*NCAP-1:0] pos, neg;
  logic              bad_code, bad_mirror, all_vcm, idle;

  assign pos     = {cap_hi_p_o, cap_lo_p_o};
  assign neg     = {cap_hi_n_o, cap_lo_n_o};
  assign all_vcm = (pos == '0) && (neg == '0);
  assign idle    = !sample_o && !cmp_strobe_o;

  always_comb begin
    bad_code   = 1'b0;
    bad_mirror = 1'b0;
    for (int j = 0; j < NCAP; j++) begin
      if (pos[2*j +: 2] == 2'b11 || neg[2*j +: 2] == 2'b11) bad_code = 1'b1;
      if (pos[2*j +: 2] != {neg[2*j], neg[2*j+1]})        bad_mirror = 1'b1;
    end
  end

  p_code_legal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni) !bad_code);
  p_mirror_r3:     assert property (@(posedge clk_i) disable iff (!rst_ni) !bad_mirror);
  p_sample_vcm_r1: assert property (@(posedge clk_i) disable iff (!rst_ni) sample_o |-> all_vcm);
  p_excl_r2:       assert property (@(posedge clk_i) disable iff (!rst_ni) !(sample_o && cmp_strobe_o));
  p_first_vcm_r2:  assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(cmp_strobe_o) |-> all_vcm);
  p_handoff_r2:    assert property (@(posedge clk_i) disable iff (!rst_ni) $fell(sample_o) |-> cmp_strobe_o);
  p_done_vcm_r6:   assert property (@(posedge clk_i) disable iff (!rst_ni) done_o |-> all_vcm && idle);
  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni) done_o |=> !done_o);
  p_hold_r7:       assert property (@(posedge clk_i) disable iff (!rst_ni)
                                    (idle && $past(idle)) |-> $stable(result_o));
  p_no_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni) cmp_strobe_o |=> !sample_o);
endmodule

bind sar_vcm_ctrl sar_vcm_ctrl_chk #(
  .NBITS(NBITS), .NHI(NHI), .SAMPLE_CYC(SAMPLE_CYC)
) i_chk (.*);

// File: tb/test_sar_vcm_ctrl.sv
`timescale 1ns/1ps
module test_sar_vcm_ctrl;
  localparam int NB  = 12;
  localparam int NC  = 11;
  localparam int NLO = 5;
  localparam int SC  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic cmp;
  logic sample, strobe, done;
  logic [11:0] hi_p, hi_n;
  logic [9:0]  lo_p, lo_n;
  logic [11:0] result;

  int target = 0;
  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  sar_vcm_ctrl i_sar_vcm_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmp_i(cmp),
    .sample_o(sample), .cmp_strobe_o(strobe),
    .cap_hi_p_o(hi_p), .cap_hi_n_o(hi_n), .cap_lo_p_o(lo_p), .cap_lo_n_o(lo_n),
    .result_o(result), .done_o(done)
  );

  logic [21:0] pos_all, neg_all;
  assign pos_all = {hi_p, lo_p};
  assign neg_all = {hi_n, lo_n};

  // ideal charge balance, doubled to keep the comparison away from zero
  always_comb begin
    int v;
    v = (target - 2048) * 2 + 1;
    for (int j = 0; j < NC; j++) begin
      if (pos_all[2*j +: 2] == 2'b01) v = v - (2 << j);
      else if (pos_all[2*j +: 2] == 2'b10) v = v + (2 << j);
    end
    cmp = (v > 0);
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_lvls(input int exp_p[NC], input string tag);
    for (int j = 0; j < NC; j++) begin
      int en;
      en = (exp_p[j] == 1) ? 2 : (exp_p[j] == 2) ? 1 : 0;
      chk(int'(pos_all[2*j +: 2]), exp_p[j], tag);
      chk(int'(neg_all[2*j +: 2]), en, tag);
    end
  endtask

  task automatic run_conv(input int code, input bit noisy);
    int exp_p[NC];
    for (int j = 0; j < NC; j++) exp_p[j] = 0;
    target = code;
    start = 1'b1;
    tick();
    start = noisy;
    chk(int'(result), 0, "R7 cleared at sample");
    for (int s = 0; s < SC; s++) begin
      chk(int'(sample), 1, "R1 sample window");
      chk(int'(strobe), 0, "R2 no strobe while sampling");
      chk_lvls(exp_p, "R1 vcm while sampling");
      tick();
    end
    for (int k = NB - 1; k >= 0; k--) begin
      int mask;
      mask = ~((1 << (k + 1)) - 1) & 12'hFFF;
      chk(int'(strobe), 1, "R2 strobe train");
      chk(int'(sample), 0, "R8 no restart of sampling");
      chk(int'(done), 0, "R6 no early done");
      chk_lvls(exp_p, "R3 R4 R10 driver pattern");
      chk(int'(result), code & mask, "R5 partial result");
      if (k >= 1) exp_p[k-1] = ((code >> k) & 1) ? 1 : 2;
      start = noisy && (k > 0) && (k % 2 == 1);
      tick();
    end
    start = 1'b0;
    chk(int'(done), 1, "R6 done pulse");
    chk(int'(strobe), 0, "R2 exactly 12 strobes");
    for (int j = 0; j < NC; j++) exp_p[j] = 0;
    chk_lvls(exp_p, "R6 drivers back to vcm");
    chk(int'(result), code, "R5 final result");
    tick();
    chk(int'(done), 0, "R6 done one cycle");
    chk(int'(result), code, "R7 result held");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R5 watchdog act=timeout exp=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int zeros[NC];
    for (int j = 0; j < NC; j++) zeros[j] = 0;
    @(negedge clk);
    start = 1'b1;
    tick();
    chk(int'(sample), 0, "R9 reset sample");
    chk(int'(strobe), 0, "R9 reset strobe");
    chk(int'(done), 0, "R9 reset done");
    chk(int'(result), 0, "R9 reset result");
    chk_lvls(zeros, "R9 reset drivers");
    start = 1'b0;
    rst_n = 1'b1;
    tick();
    chk(int'(sample), 0, "R9 idle after reset");
    for (int code = 0; code < 4096; code++) begin
      run_conv(code, (code % 7) == 3);
      for (int i = 0; i < code % 3; i++) begin
        tick();
        chk(int'(sample), 0, "R8 idle stays idle");
        chk(int'(done), 0, "R6 no repeat done");
        chk(int'(result), code, "R7 idle hold");
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule